// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller

This block is a register-mapped SPI master. Software reaches it over a simple synchronous bus with three byte registers: control, status and data. When the controller is enabled and set to master, a write to the data register starts an 8-bit full-duplex exchange. The byte goes out on MOSI most significant bit first, and the byte on MISO is captured at the same time. The serial clock is the system clock divided by 2, 4, 16 or 32. Clock polarity and clock phase are both selectable.

Three sticky status flags report what happened: transfer done, write collision and mode fault. Each flag is cleared only by a two-step access sequence. The first step is a status read made while the flag is set. The second step is a data-register access for the done and collision flags, or a control-register write for the mode fault. A low level on the slave-select input while in master mode counts as a bus conflict. It drops the controller out of master mode and out of enable, and it aborts any exchange in progress. An interrupt output, gated by an enable bit, follows the done and mode-fault flags.

Top module: `spi_ctl_top`

## Requirements
- R1: Address 0 is control, 1 is status and 2 is data. Control bits from 7 down to 0 are: interrupt enable, controller enable, open-drain select (driven out on `od_sel_o`), master select, clock polarity, clock phase, and rate select in bits 1:0. Control resets to 0x00 and reads back what was written. A read returns data on `bus_rdata` in the cycle after the read strobe.
- R2: Rate select values 0, 1, 2 and 3 divide the system clock by 2, 4, 16 and 32. One exchange gives exactly 16 SCK transitions. `irq_o` rises 16*D/2+2 clock edges after the edge that takes the data write, where D is the divide ratio.
- R3: Outside an exchange, SCK rests at the clock-polarity bit.
- R4: With phase 0, MOSI holds the first bit before the first SCK edge, and MISO is sampled on odd-numbered SCK edges. With phase 1, MOSI changes on odd-numbered edges and MISO is sampled on even-numbered edges. Data goes out MSB first. A data read returns the captured byte, so a MOSI-to-MISO loopback returns the transmitted byte.
- R5: A data write starts an exchange only while both enable and master are 1. Otherwise SCK does not move.
- R6: The status register holds transfer-done in bit 7, write collision in bit 6 and mode fault in bit 4, and all other bits read 0. Transfer-done is set when an exchange completes.
- R7: Transfer-done clears on a data access (read or write) that follows a status read made while the flag was set. A status read made while the flag was clear does not arm the clear. Other accesses between the two steps do not cancel it.
- R8: A data write during an exchange sets write collision and is discarded. The byte in flight is not changed.
- R9: Write collision clears by the same status-read then data-access sequence as transfer-done.
- R10: While enable and master are both 1, `ss_n_i` low (after a 2-stage synchronizer) sets mode fault, clears the enable and master bits, aborts the exchange and returns SCK to idle without setting transfer-done.
- R11: Mode fault clears on a control write that follows a status read made while mode fault was set. A control write without that read leaves it set.
- R12: `irq_o` is a register that goes high one cycle after interrupt enable is 1 and transfer-done or mode fault is set. It stays low while interrupt enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select input, active low, used for conflict detection |
| od_sel_o | output | 1 | Open-drain select for the pad logic |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the clear sequences. A status read taken before a transfer finishes must not arm the later data read. A design that arms on any status read would lose the done flag. A collision write in the middle of a slow transfer must leave the received byte intact; a design that loads the shift register on every write would return the colliding byte. A mode fault during a transfer must kill SCK and block the done flag. A control write without a prior status read must leave the fault set, which catches a design that clears the fault on any control write. Cycle counts at all four rates, the SCK transition count and both phase settings under loopback catch divider and edge-ordering mistakes.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2
  } reg_addr_e;

  // control register field positions (software-visible)
  localparam int CB_IE   = 7;
  localparam int CB_EN   = 6;
  localparam int CB_OD   = 5;
  localparam int CB_MS   = 4;
  localparam int CB_CPOL = 3;
  localparam int CB_CPHA = 2;

  // half SCK period in system clocks for each rate code
  function automatic logic [4:0] half_period(input logic [1:0] rate);
    case (rate)
      2'd0:    half_period = 5'd1;
      2'd1:    half_period = 5'd2;
      2'd2:    half_period = 5'd8;
      default: half_period = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/spi_ss_sync.sv
module spi_ss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '1;
    else     pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  import spi_ctl_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'(half_period(rate) - 5'd1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         abort,
  input  logic         tick,
  input  logic [W-1:0] tx_byte,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic         sck,
  output logic         mosi,
  output logic [W-1:0] rx_byte
);
  localparam int EDGES = 2 * W;
  localparam int EC_W  = $clog2(EDGES);
  localparam logic [EC_W-1:0] LAST_EDGE = EC_W'(EDGES - 1);

  logic [EC_W-1:0] edge_q;
  logic [W-1:0]    tx_sh_q;
  logic [W-1:0]    rx_sh_q;
  logic [W-1:0]    rx_next;
  logic            lead_edge;
  logic            sample_edge;
  logic            last_edge;

  assign rx_next     = {rx_sh_q[W-2:0], miso};
  assign lead_edge   = ~edge_q[0];
  assign sample_edge = lead_edge ^ cpha;
  assign last_edge   = (edge_q == LAST_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      edge_q  <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
        sck  <= cpol;
      end else if (start) begin
        busy    <= 1'b1;
        edge_q  <= '0;
        sck     <= cpol;
        rx_sh_q <= '0;
        if (!cpha) begin
          mosi    <= tx_byte[W-1];
          tx_sh_q <= {tx_byte[W-2:0], 1'b0};
        end else begin
          tx_sh_q <= tx_byte;
        end
      end else if (busy && tick) begin
        sck    <= ~sck;
        edge_q <= edge_q + 1'b1;
        if (sample_edge) begin
          rx_sh_q <= rx_next;
        end else if (!last_edge) begin
          mosi    <= tx_sh_q[W-1];
          tx_sh_q <= {tx_sh_q[W-2:0], 1'b0};
        end
        if (last_edge) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= sample_edge ? rx_next : rx_sh_q;
        end
      end else if (!busy) begin
        sck <= cpol;
      end
    end
  end
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             busy,
  input  logic             done,
  input  logic [REG_W-1:0] rx_byte,
  input  logic             ss_low,
  output logic [REG_W-1:0] ctrl_q,
  output logic             start,
  output logic             abort,
  output logic             spif_q,
  output logic             wcol_q,
  output logic             modf_q,
  output logic             irq
);
  logic ctrl_wr, stat_rd, data_acc, data_wr, master_on;
  logic modf_evt, wcol_evt;
  logic spif_arm_q, wcol_arm_q, modf_arm_q;
  logic spif_clr, wcol_clr, modf_clr;
  logic [REG_W-1:0] stat_word;

  assign ctrl_wr   = sel && wr && (addr == ADR_CTRL);
  assign stat_rd   = sel && !wr && (addr == ADR_STAT);
  assign data_acc  = sel && (addr == ADR_DATA);
  assign data_wr   = data_acc && wr;
  assign master_on = ctrl_q[CB_EN] && ctrl_q[CB_MS];

  assign modf_evt  = master_on && ss_low;
  assign wcol_evt  = data_wr && busy;
  assign start     = data_wr && !busy && master_on && !modf_evt;
  assign abort     = modf_evt || (ctrl_wr && !(wdata[CB_EN] && wdata[CB_MS]));

  assign spif_clr  = data_acc && spif_arm_q;
  assign wcol_clr  = data_acc && wcol_arm_q;
  assign modf_clr  = ctrl_wr && modf_arm_q;

  assign stat_word = {spif_q, wcol_q, 1'b0, modf_q, 4'b0000};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= wdata;
      if (modf_evt) begin
        ctrl_q[CB_EN] <= 1'b0;
        ctrl_q[CB_MS] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spif_q     <= 1'b0;
      spif_arm_q <= 1'b0;
    end else if (done) begin
      spif_q     <= 1'b1;
      spif_arm_q <= 1'b0;
    end else if (spif_clr) begin
      spif_q     <= 1'b0;
      spif_arm_q <= 1'b0;
    end else if (stat_rd && spif_q) begin
      spif_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcol_q     <= 1'b0;
      wcol_arm_q <= 1'b0;
    end else if (wcol_evt) begin
      wcol_q     <= 1'b1;
      wcol_arm_q <= 1'b0;
    end else if (wcol_clr) begin
      wcol_q     <= 1'b0;
      wcol_arm_q <= 1'b0;
    end else if (stat_rd && wcol_q) begin
      wcol_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modf_q     <= 1'b0;
      modf_arm_q <= 1'b0;
    end else if (modf_evt) begin
      modf_q     <= 1'b1;
      modf_arm_q <= 1'b0;
    end else if (modf_clr) begin
      modf_q     <= 1'b0;
      modf_arm_q <= 1'b0;
    end else if (stat_rd && modf_q) begin
      modf_arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !wr) begin
      case (addr)
        ADR_CTRL: rdata <= ctrl_q;
        ADR_STAT: rdata <= stat_word;
        ADR_DATA: rdata <= rx_byte;
        default:  rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= ctrl_q[CB_IE] && (spif_q || modf_q);
  end
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_CNT_W   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       ss_n_i,
  output logic       od_sel_o,
  output logic       irq_o
);
  import spi_ctl_pkg::*;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] rx_byte;
  logic ss_sync_n;
  logic xfer_start, xfer_abort, xfer_busy, xfer_done, div_tick;
  logic spif_q, wcol_q, modf_q;

  spi_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ss_n_i),
    .dout(ss_sync_n)
  );

  spi_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .busy   (xfer_busy),
    .done   (xfer_done),
    .rx_byte(rx_byte),
    .ss_low (~ss_sync_n),
    .ctrl_q (ctrl_q),
    .start  (xfer_start),
    .abort  (xfer_abort),
    .spif_q (spif_q),
    .wcol_q (wcol_q),
    .modf_q (modf_q),
    .irq    (irq_o)
  );

  spi_clk_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk (clk),
    .rst (rst),
    .run (xfer_busy),
    .rate(ctrl_q[1:0]),
    .tick(div_tick)
  );

  spi_shift #(.W(REG_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .start  (xfer_start),
    .abort  (xfer_abort),
    .tick   (div_tick),
    .tx_byte(bus_wdata),
    .cpol   (ctrl_q[CB_CPOL]),
    .cpha   (ctrl_q[CB_CPHA]),
    .miso   (miso_i),
    .busy   (xfer_busy),
    .done   (xfer_done),
    .sck    (sck_o),
    .mosi   (mosi_o),
    .rx_byte(rx_byte)
  );

  assign od_sel_o = ctrl_q[CB_OD];
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic cpol,
  input logic ie,
  input logic en,
  input logic ms,
  input logic busy,
  input logic done,
  input logic spif,
  input logic wcol,
  input logic modf,
  input logic irq
);
  // R5
  busy_mode_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (en && ms));

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && $stable(cpol)) |-> (sck == cpol));

  // R6
  spif_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(spif) |-> $past(done));

  // R8
  wcol_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wcol) |-> $past(busy));

  // R10
  modf_abort_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(modf) |-> (!busy && !ms && !en));

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);

  // R12
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(spif || modf));
endmodule

bind spi_ctl_top spi_ctl_chk u_chk (
  .clk (clk),
  .rst (rst),
  .sck (sck_o),
  .cpol(ctrl_q[3]),
  .ie  (ctrl_q[7]),
  .en  (ctrl_q[6]),
  .ms  (ctrl_q[4]),
  .busy(xfer_busy),
  .done(xfer_done),
  .spif(spif_q),
  .wcol(wcol_q),
  .modf(modf_q),
  .irq (irq_o)
);

// File: tb/spi_ctl_top_test.sv
`timescale 1ns/1ps
module spi_ctl_top_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       sck_o, mosi_o, od_sel_o, irq_o;
  logic       ss_n = 1'b1;
  logic       loop_sel = 1'b1;
  logic       miso;

  int checks = 0;
  int errors = 0;
  int sck_edges = 0;

  always #4 clk = ~clk;

  assign miso = loop_sel ? mosi_o : 1'b1;

  always @(sck_o) sck_edges++;

  spi_ctl_top uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso), .ss_n_i(ss_n),
    .od_sel_o(od_sel_o), .irq_o(irq_o)
  );

  // vector: ctrl[40:33] tx[32:25] loop[24] rx[23:16] cycles-to-irq[15:0]
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {8'hD0, 8'hA5, 1'b1, 8'hA5, 16'd18},
    {8'hD5, 8'h3C, 1'b1, 8'h3C, 16'd34},
    {8'hDA, 8'h81, 1'b1, 8'h81, 16'd130},
    {8'hDF, 8'h5A, 1'b0, 8'hFF, 16'd258},
    {8'hF0, 8'h00, 1'b0, 8'hFF, 16'd18},
    {8'hD4, 8'hFF, 1'b1, 8'hFF, 16'd18}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_o && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int n, e0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // reset state
    bus_read(2'd0, rd); check("R1 ctrl reset", rd, 8'h00);
    bus_read(2'd1, rd); check("R6 status reset", rd, 8'h00);
    check("R3 sck reset", sck_o, 0);
    check("R12 irq reset", irq_o, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [40:0] v;
      v = VEC[i];
      loop_sel = v[24];
      bus_write(2'd0, v[40:33]);
      bus_read(2'd0, rd); check("R1 ctrl readback", rd, v[40:33]);
      check("R1 od select pin", od_sel_o, v[38]);
      check("R3 idle level", sck_o, v[36]);
      e0 = sck_edges;
      bus_write(2'd2, v[32:25]);
      wait_irq(n);
      check("R2 cycles to irq", n, v[15:0]);
      check("R2 sck transitions", sck_edges - e0, 16);
      check("R3 idle after xfer", sck_o, v[36]);
      bus_read(2'd1, rd); check("R6 status done", rd, 8'h80);
      bus_read(2'd2, rd); check("R4 rx byte", rd, v[23:16]);
      bus_read(2'd1, rd); check("R7 done cleared", rd, 8'h00);
      check("R12 irq drops", irq_o, 0);
    end
    loop_sel = 1'b1;

    // R5: enable without master does not start
    bus_write(2'd0, 8'h40);
    e0 = sck_edges;
    bus_write(2'd2, 8'hC3);
    idle(40);
    check("R5 no sck without master", sck_edges - e0, 0);
    bus_read(2'd1, rd); check("R5 no done without master", rd, 8'h00);

    // R8/R9: collision during slow transfer
    bus_write(2'd0, 8'hD3);
    bus_write(2'd2, 8'h96);
    idle(20);
    bus_write(2'd2, 8'h11);
    wait_irq(n);
    bus_read(2'd1, rd); check("R8 collision flagged", rd, 8'hC0);
    bus_read(2'd0, rd); check("R7 intervening ctrl read", rd, 8'hD3);
    bus_read(2'd2, rd); check("R8 byte not corrupted", rd, 8'h96);
    bus_read(2'd1, rd); check("R9 collision cleared", rd, 8'h00);

    // R7: status read while clear does not arm
    bus_write(2'd0, 8'hD1);
    bus_write(2'd2, 8'h42);
    bus_read(2'd1, rd); check("R7 status during xfer", rd, 8'h00);
    wait_irq(n);
    bus_read(2'd2, rd); check("R4 rx after early read", rd, 8'h42);
    bus_read(2'd1, rd); check("R7 unarmed clear ignored", rd, 8'h80);
    bus_read(2'd2, rd);
    bus_read(2'd1, rd); check("R7 armed clear", rd, 8'h00);

    // R10/R11: mode fault aborts transfer
    bus_write(2'd0, 8'hD3);
    bus_write(2'd2, 8'h77);
    idle(10);
    ss_n = 1'b0;
    idle(4);
    ss_n = 1'b1;
    idle(4);
    check("R10 sck idle after fault", sck_o, 0);
    check("R12 irq on fault", irq_o, 1);
    bus_read(2'd0, rd); check("R10 enable and master cleared", rd, 8'h83);
    idle(300);
    bus_write(2'd0, 8'h83);
    bus_read(2'd1, rd); check("R11 unarmed ctrl write keeps fault; R10 no done", rd, 8'h10);
    bus_write(2'd0, 8'h00);
    bus_read(2'd1, rd); check("R11 fault cleared", rd, 8'h00);
    check("R12 irq low after clear", irq_o, 0);

    // R12: interrupt masked
    bus_write(2'd0, 8'h50);
    bus_write(2'd2, 8'h33);
    idle(40);
    check("R12 masked irq", irq_o, 0);
    bus_read(2'd1, rd); check("R6 polled done", rd, 8'h80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule